// File: doc/BRIEF.md
# Event Timer Interrupt Control Unit

This block is the global control and interrupt status section of an event timer that has three timers. A 64-bit register port with address, write data, write enable and combinational read data gives access to two registers. The configuration register holds a unit enable and a legacy-routing select. The status register holds one pending bit for each timer. The comparators, the main counter and the per-timer configuration sit outside this block. They deliver a per-timer event signal, a trigger-mode input and a route index.

The unit drives a run enable toward the main counter. It also builds two interrupt request vectors: a 16-line vector for the legacy interrupt controller and a 24-line vector for the advanced interrupt controller. Level-mode timers latch their events into write-one-to-clear status bits. Edge-mode timers pass their events straight through as pulses. While the legacy-routing select is on, timers 0 and 1 go to fixed lines and their route indexes are ignored.

Top module: `evt_irq_ctrl`

## Requirements
- R1: The configuration register sits at offset 0x010 and resets to zero. Bit 0 is the unit enable and bit 1 is the legacy-routing select. Both bits read back what was written, and bits 63:2 read as zero.
- R2: `cnt_run` follows the unit enable. While the enable is 0, every bit of `irq_leg` and `irq_adv` is low, and no status bit becomes set.
- R3: When the enable and the legacy-routing select are both 1, timer 0 drives `irq_leg[0]` and `irq_adv[2]`, and timer 1 drives `irq_leg[8]` and `irq_adv[8]`. The route indexes of timers 0 and 1 have no effect in this state.
- R4: Timer 2 always uses its own route index. When legacy routing is off, every timer uses its own route index. A timer drives `irq_adv[idx]`, where idx is the 5-bit field at `tmr_route[5t+4:5t]`. An index of 24 or more drives no line. Outside legacy routing, `irq_leg` stays low.
- R5: The status register sits at offset 0x020 and resets to zero. Bit t holds the status of timer t for t = 0..2, and bits 63:3 read as zero.
- R6: A timer is in level mode when `tmr_lvl[t]` is 1. In level mode, an enabled cycle with `tmr_evt[t]` high sets status bit t at the next clock edge. Writing 1 to bit t at 0x020 clears it, and writing 0 leaves it unchanged.
- R7: A timer is in edge mode when `tmr_lvl[t]` is 0. In edge mode, its status bit reads 0 and writes to it are ignored. Its request line is high in exactly the cycles where `tmr_evt[t]` is high and the unit is enabled.
- R8: Clearing the enable leaves set level-mode status bits set. Once the enable is set again, the request line of such a timer is asserted again.
- R9: If a level-mode event and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R10: Reads of any offset other than 0x010 and 0x020 return zero, and writes to them change nothing.
- R11: A level-mode timer holds its request line high for as long as its status bit is set and the unit is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 64 | Register read data (combinational) |
| tmr_evt | input | 3 | Per-timer event from the comparators |
| tmr_lvl | input | 3 | Per-timer trigger mode, 1 = level |
| tmr_route | input | 15 | Per-timer 5-bit advanced-controller line index |
| cnt_run | output | 1 | Main counter run enable |
| irq_leg | output | 16 | Requests toward the legacy controller |
| irq_adv | output | 24 | Requests toward the advanced controller |

## Verification
The bench puts a status-clear write and a level event into the same cycle. A design where the clear takes priority would lose that event and read the bit as 0. It turns the unit off while a level status bit is pending. A design that flushes status on disable would read 0 afterwards, and one that does not gate by the enable would keep the request line high. It sets all three timers to fire with legacy routing on and again with it off, and gives timers 0 and 1 route indexes that would show up on distinct lines if they were wrongly honoured. It also gives timer 2 an out-of-range index, which must produce no line. Edge-mode timers are written with ones to catch a status bit that latches or that can be written.

// File: rtl/evt_pkg.sv
// Package: shared constants and types of the event timer interrupt control unit.
// Assumes a 12-bit byte offset space; register offsets are fixed here.
package evt_pkg;
    localparam int          EVT_ADDR_W   = 12;
    localparam logic [11:0] EVT_CFG_OFS  = 12'h010;
    localparam logic [11:0] EVT_STS_OFS  = 12'h020;

    // Fixed lines used while legacy routing is active.
    localparam int EVT_T0_LEG_LINE = 0;
    localparam int EVT_T0_ADV_LINE = 2;
    localparam int EVT_T1_LEG_LINE = 8;
    localparam int EVT_T1_ADV_LINE = 8;

    // Configuration register fields.
    typedef struct packed {
        logic leg_route;   // bit 1
        logic unit_en;     // bit 0
    } evt_cfg_t;
endpackage

// File: rtl/evt_cfg_reg.sv
// Module: configuration register. Holds the unit enable and the legacy-routing
// select. Assumes a single-cycle write strobe; unmatched offsets are ignored.
module evt_cfg_reg
    import evt_pkg::*;
#(
    parameter int ADDR_W = EVT_ADDR_W,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    output evt_cfg_t          cfg_q
);
    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(EVT_CFG_OFS);

    logic hit;

    // Decode a write to the configuration offset.
    always_comb begin
        hit = wr_en && (wr_addr == CFG_ADDR);
    end

    // Store the two live configuration bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (hit) begin
            cfg_q.unit_en   <= wr_data[0];
            cfg_q.leg_route <= wr_data[1];
        end
    end
endmodule

// File: rtl/evt_status.sv
// Module: per-timer interrupt status and request source. Level-mode timers
// latch events into write-one-to-clear bits (set has priority); edge-mode
// timers keep the bit at zero and pass events through. Everything is gated
// by the unit enable.
module evt_status #(
    parameter int NUM_TMR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unit_en,
    input  logic [NUM_TMR-1:0] evt,
    input  logic [NUM_TMR-1:0] lvl,
    input  logic               clr_we,
    input  logic [NUM_TMR-1:0] clr_mask,
    output logic [NUM_TMR-1:0] sts_q,
    output logic [NUM_TMR-1:0] src
);
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        logic set_t;
        logic clr_t;

        // Qualify the hardware set and the software clear for this timer.
        always_comb begin
            set_t = unit_en && evt[t];
            clr_t = clr_we && clr_mask[t];
        end

        // Status bit: held at zero in edge mode, set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_q[t] <= 1'b0;
            end else if (!lvl[t]) begin
                sts_q[t] <= 1'b0;
            end else if (set_t) begin
                sts_q[t] <= 1'b1;
            end else if (clr_t) begin
                sts_q[t] <= 1'b0;
            end
        end

        // Request source: latched status in level mode, raw event in edge mode.
        always_comb begin
            src[t] = unit_en && (lvl[t] ? sts_q[t] : evt[t]);
        end
    end
endmodule

// File: rtl/evt_router.sv
// Module: maps per-timer request sources onto the legacy and advanced
// controller lines. Timers 0 and 1 take fixed lines under legacy routing;
// otherwise each timer uses its route index, and out-of-range indexes drop.
module evt_router
    import evt_pkg::*;
#(
    parameter int NUM_TMR = 3,
    parameter int LEG_W   = 16,
    parameter int ADV_W   = 24,
    parameter int ROUTE_W = $clog2(ADV_W)
) (
    input  logic                       leg_act,
    input  logic [NUM_TMR-1:0]         src,
    input  logic [NUM_TMR*ROUTE_W-1:0] route,
    output logic [LEG_W-1:0]           irq_leg,
    output logic [ADV_W-1:0]           irq_adv
);
    localparam logic [ROUTE_W:0] ADV_LIMIT = (ROUTE_W+1)'(ADV_W);

    // Combine every timer's contribution onto the output lines.
    always_comb begin
        irq_leg = '0;
        irq_adv = '0;
        for (int t = 0; t < NUM_TMR; t++) begin
            logic [ROUTE_W-1:0] idx;
            idx = route[t*ROUTE_W +: ROUTE_W];
            if (leg_act && t == 0) begin
                irq_leg[EVT_T0_LEG_LINE] = irq_leg[EVT_T0_LEG_LINE] | src[t];
                irq_adv[EVT_T0_ADV_LINE] = irq_adv[EVT_T0_ADV_LINE] | src[t];
            end else if (leg_act && t == 1) begin
                irq_leg[EVT_T1_LEG_LINE] = irq_leg[EVT_T1_LEG_LINE] | src[t];
                irq_adv[EVT_T1_ADV_LINE] = irq_adv[EVT_T1_ADV_LINE] | src[t];
            end else if ({1'b0, idx} < ADV_LIMIT) begin
                irq_adv[idx] = irq_adv[idx] | src[t];
            end
        end
    end
endmodule

// File: rtl/evt_rdmux.sv
// Module: read data multiplexer. Returns the configuration or status
// register at their offsets and zero everywhere else.
module evt_rdmux
    import evt_pkg::*;
#(
    parameter int ADDR_W  = EVT_ADDR_W,
    parameter int DATA_W  = 64,
    parameter int NUM_TMR = 3
) (
    input  logic [ADDR_W-1:0]  rd_addr,
    input  evt_cfg_t           cfg_q,
    input  logic [NUM_TMR-1:0] sts_q,
    output logic [DATA_W-1:0]  rd_data
);
    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(EVT_CFG_OFS);
    localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(EVT_STS_OFS);

    // Select the addressed register, zero-extended.
    always_comb begin
        rd_data = '0;
        if (rd_addr == CFG_ADDR) begin
            rd_data[1:0] = {cfg_q.leg_route, cfg_q.unit_en};
        end else if (rd_addr == STS_ADDR) begin
            rd_data[NUM_TMR-1:0] = sts_q;
        end
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
// Module: top of the event timer interrupt control unit. Connects the
// configuration register, status logic, router and read multiplexer.
// Assumes the per-timer mode and route inputs are stable, synchronous signals.
module evt_irq_ctrl
    import evt_pkg::*;
#(
    parameter int NUM_TMR = 3,
    parameter int ADDR_W  = EVT_ADDR_W,
    parameter int DATA_W  = 64,
    parameter int LEG_W   = 16,
    parameter int ADV_W   = 24,
    parameter int ROUTE_W = $clog2(ADV_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    input  logic                       reg_we,
    output logic [DATA_W-1:0]          reg_rdata,
    input  logic [NUM_TMR-1:0]         tmr_evt,
    input  logic [NUM_TMR-1:0]         tmr_lvl,
    input  logic [NUM_TMR*ROUTE_W-1:0] tmr_route,
    output logic                       cnt_run,
    output logic [LEG_W-1:0]           irq_leg,
    output logic [ADV_W-1:0]           irq_adv
);
    localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(EVT_STS_OFS);

    evt_cfg_t           cfg;
    logic [NUM_TMR-1:0] sts_q;
    logic [NUM_TMR-1:0] src;
    logic               sts_clr_we;
    logic               leg_act;

    // Derive the status-clear strobe and the legacy-routing qualifier.
    always_comb begin
        sts_clr_we = reg_we && (reg_addr == STS_ADDR);
        leg_act    = cfg.unit_en && cfg.leg_route;
        cnt_run    = cfg.unit_en;
    end

    evt_cfg_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .wr_en   (reg_we),
        .cfg_q   (cfg)
    );

    evt_status #(.NUM_TMR(NUM_TMR)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .unit_en  (cfg.unit_en),
        .evt      (tmr_evt),
        .lvl      (tmr_lvl),
        .clr_we   (sts_clr_we),
        .clr_mask (reg_wdata[NUM_TMR-1:0]),
        .sts_q    (sts_q),
        .src      (src)
    );

    evt_router #(
        .NUM_TMR(NUM_TMR), .LEG_W(LEG_W), .ADV_W(ADV_W), .ROUTE_W(ROUTE_W)
    ) u_rte (
        .leg_act (leg_act),
        .src     (src),
        .route   (tmr_route),
        .irq_leg (irq_leg),
        .irq_adv (irq_adv)
    );

    evt_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_TMR(NUM_TMR)) u_rd (
        .rd_addr (reg_addr),
        .cfg_q   (cfg),
        .sts_q   (sts_q),
        .rd_data (reg_rdata)
    );
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
// Module: assertion checker bound to evt_irq_ctrl.
module evt_irq_ctrl_chk
    import evt_pkg::*;
#(
    parameter int NUM_TMR = 3,
    parameter int ADDR_W  = EVT_ADDR_W,
    parameter int DATA_W  = 64,
    parameter int LEG_W   = 16,
    parameter int ADV_W   = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic [NUM_TMR-1:0] tmr_evt,
    input logic [NUM_TMR-1:0] tmr_lvl,
    input logic               cnt_run,
    input logic [LEG_W-1:0]   irq_leg,
    input logic [ADV_W-1:0]   irq_adv,
    input logic [NUM_TMR-1:0] sts_q,
    input logic               sts_clr_we
);
    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(EVT_CFG_OFS);
    localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(EVT_STS_OFS);

    p_cfg_rsvd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == CFG_ADDR) |-> (reg_rdata[DATA_W-1:2] == '0));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_run |-> (irq_leg == '0 && irq_adv == '0));

    p_sts_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == STS_ADDR) |-> (reg_rdata[DATA_W-1:NUM_TMR] == '0));

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
        p_edge_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == STS_ADDR && !tmr_lvl[t]) |-> !reg_rdata[t]);

        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_run && tmr_lvl[t] && tmr_evt[t]) |=> (sts_q[t] || !tmr_lvl[t]));

        p_hold_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_q[t] && tmr_lvl[t] && !(sts_clr_we && reg_wdata[t]))
                |=> (sts_q[t] || !tmr_lvl[t]));
    end
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
    .NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LEG_W(LEG_W), .ADV_W(ADV_W)
) u_evt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .tmr_evt    (tmr_evt),
    .tmr_lvl    (tmr_lvl),
    .cnt_run    (cnt_run),
    .irq_leg    (irq_leg),
    .irq_adv    (irq_adv),
    .sts_q      (sts_q),
    .sts_clr_we (sts_clr_we)
);

// File: tb/test_evt_irq_ctrl.sv
// Directed bench for evt_irq_ctrl: one task per scenario.
module test_evt_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [63:0] reg_rdata;
    logic [2:0]  tmr_evt = '0;
    logic [2:0]  tmr_lvl = '0;
    logic [14:0] tmr_route = '0;
    logic        cnt_run;
    logic [15:0] irq_leg;
    logic [23:0] irq_adv;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evt_irq_ctrl i_evt_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .tmr_evt(tmr_evt),
        .tmr_lvl(tmr_lvl), .tmr_route(tmr_route), .cnt_run(cnt_run),
        .irq_leg(irq_leg), .irq_adv(irq_adv)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Single write: drive at negedge, commit at posedge, release after.
    task automatic wr(logic [11:0] a, logic [63:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    task automatic set_route(int r0, int r1, int r2);
        tmr_route = {5'(r2), 5'(r1), 5'(r0)};
    endtask

    // One-cycle event pulse on the masked timers.
    task automatic pulse(logic [2:0] m);
        @(negedge clk); tmr_evt = m;
        @(posedge clk); #1; tmr_evt = '0;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        check("R2 reset cnt_run", 64'(cnt_run), 64'd0);
        rd(12'h010, d); check("R1 reset cfg", d, 64'd0);
        rd(12'h020, d); check("R5 reset sts", d, 64'd0);
    endtask

    task automatic t_cfg();
        logic [63:0] d;
        wr(12'h010, '1);
        rd(12'h010, d); check("R1 cfg readback", d, 64'd3);
        check("R2 cnt_run on", 64'(cnt_run), 64'd1);
        wr(12'h018, '1);
        rd(12'h018, d); check("R10 unmapped read", d, 64'd0);
        rd(12'h010, d); check("R10 unmapped write", d, 64'd3);
        wr(12'h010, 64'd0);
        rd(12'h010, d); check("R1 cfg cleared", d, 64'd0);
        check("R2 cnt_run off", 64'(cnt_run), 64'd0);
    endtask

    task automatic t_disabled();
        logic [63:0] d;
        tmr_lvl = 3'b111; set_route(1, 2, 3);
        @(negedge clk); tmr_evt = 3'b111; #1;
        check("R2 irq_adv while off", 64'(irq_adv), 64'd0);
        check("R2 irq_leg while off", 64'(irq_leg), 64'd0);
        @(posedge clk); #1; tmr_evt = '0;
        rd(12'h020, d); check("R2 no status while off", d, 64'd0);
    endtask

    task automatic t_level();
        logic [63:0] d;
        wr(12'h010, 64'd1);
        tmr_lvl = 3'b111; set_route(5, 6, 7);
        pulse(3'b001);
        rd(12'h020, d); check("R6 level set", d, 64'd1);
        check("R11 level line held", 64'(irq_adv), 64'(1) << 5);
        repeat (3) @(posedge clk);
        #1 check("R11 level line still held", 64'(irq_adv), 64'(1) << 5);
        wr(12'h020, 64'd0);
        rd(12'h020, d); check("R6 write 0 no effect", d, 64'd1);
        wr(12'h020, 64'd1);
        rd(12'h020, d); check("R6 write 1 clears", d, 64'd0);
        check("R11 line drops", 64'(irq_adv), 64'd0);
    endtask

    task automatic t_edge();
        logic [63:0] d;
        wr(12'h010, 64'd1);
        tmr_lvl = 3'b101; set_route(5, 7, 9);
        @(negedge clk); tmr_evt = 3'b010; #1;
        check("R7 edge pulse", 64'(irq_adv), 64'(1) << 7);
        @(posedge clk); #1; tmr_evt = '0;
        @(negedge clk); #1;
        check("R7 edge pulse ends", 64'(irq_adv), 64'd0);
        rd(12'h020, d); check("R7 edge status zero", d, 64'd0);
        wr(12'h020, '1);
        rd(12'h020, d); check("R7 edge write ignored", d, 64'd0);
    endtask

    task automatic t_legacy();
        wr(12'h010, 64'd3);
        tmr_lvl = 3'b000; set_route(5, 6, 9);
        @(negedge clk); tmr_evt = 3'b111; #1;
        check("R3 legacy lines", 64'(irq_leg), 64'h0101);
        check("R3 adv lines", 64'(irq_adv), (64'(1) << 2) | (64'(1) << 8) | (64'(1) << 9));
        @(posedge clk); #1; tmr_evt = '0;
    endtask

    task automatic t_own_route();
        wr(12'h010, 64'd1);
        tmr_lvl = 3'b000; set_route(5, 6, 9);
        @(negedge clk); tmr_evt = 3'b111; #1;
        check("R4 no legacy lines", 64'(irq_leg), 64'd0);
        check("R4 own routes", 64'(irq_adv), (64'(1) << 5) | (64'(1) << 6) | (64'(1) << 9));
        set_route(5, 6, 30); #1;
        check("R4 out of range index", 64'(irq_adv), (64'(1) << 5) | (64'(1) << 6));
        @(posedge clk); #1; tmr_evt = '0;
    endtask

    task automatic t_hold();
        logic [63:0] d;
        wr(12'h010, 64'd1);
        tmr_lvl = 3'b100; set_route(5, 6, 9);
        pulse(3'b100);
        wr(12'h010, 64'd0);
        rd(12'h020, d); check("R8 held after disable", d, 64'd4);
        check("R8 line off while disabled", 64'(irq_adv), 64'd0);
        wr(12'h010, 64'd1); #1;
        check("R8 line back on enable", 64'(irq_adv), 64'(1) << 9);
        wr(12'h020, 64'd4);
    endtask

    task automatic t_set_wins();
        logic [63:0] d;
        wr(12'h010, 64'd1);
        tmr_lvl = 3'b001;
        @(negedge clk);
        reg_addr = 12'h020; reg_wdata = 64'd1; reg_we = 1'b1; tmr_evt = 3'b001;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_wdata = '0; tmr_evt = '0;
        rd(12'h020, d); check("R9 set wins over clear", d, 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_cfg();
        t_disabled();
        t_level();
        t_edge();
        t_legacy();
        t_own_route();
        t_hold();
        t_set_wins();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule